// File: doc/BRIEF.md
# SMRAM Control Register with High-Window Remap

This block holds the 8-bit control register for extended system-management memory and the address-check logic that the register steers. Software reads and writes the register through a small configuration port at a single byte offset. Two enable bits can be written until an external lock input is raised. Three fixed indicator bits always read as one. An error flag records illegal accesses and is cleared by writing a one to it.

Every valid access on the access-check port is compared against two windows. The first is the high SMRAM window at 0xFEDA0000 to 0xFEDBFFFF. It is active only while the global SMRAM enable and the high-enable bit are both 1, and a hit there is moved onto the legacy range 0x000A0000 to 0x000BFFFF. The second is the TSEG range, whose base and top arrive on input ports. It is active only while the global enable and the TSEG-enable bit are both 1, and a hit there passes the address through unchanged.

A hit made from outside system-management mode, while the open input is low, sets the error flag. All outputs are registered and appear one clock after the request.

Top module: `smram_ctl`

## Requirements
- R1: After a synchronous reset, the register reads 0x38, `err_status` is 0 and `acc_hit` is 0.
- R2: A read with `cfg_addr` = 0x9E returns the register value on `cfg_rdata` one cycle later, with layout {high_en[7], err[6], 3'b111[5:3], 2'b00[2:1], tseg_en[0]}. Any other read returns 0, and writes to any other offset change nothing.
- R3: Bits 5, 4 and 3 always read 1 and bits 2:1 always read 0, whatever value is written.
- R4: While `lock_in` is 0, a write to 0x9E loads bit 7 and bit 0 from the write data. While `lock_in` is 1, such a write leaves both bits unchanged.
- R5: When `glob_en` and bit 7 are both 1, a valid access with address in 0xFEDA0000..0xFEDBFFFF gives `acc_hit` = 1 and `dram_addr` = 0x000A0000 | addr[16:0] one cycle later. This applies even when the address is also inside the TSEG range.
- R6: When `glob_en` and bit 0 are both 1, a valid access with `tseg_base` <= addr < `tseg_top` that misses the high window gives `acc_hit` = 1 and `dram_addr` = addr one cycle later.
- R7: A valid access that hits no active window gives `acc_hit` = 0 and `dram_addr` = addr. A cycle with no valid access gives `acc_hit` = 0 and `dram_addr` = 0.
- R8: A hit (R5 or R6) with `acc_in_smm` = 0 and `open_in` = 0 sets bit 6 at the next edge. A hit with either of those inputs at 1 does not set it.
- R9: A write of 1 to bit 6 at 0x9E clears it. A write of 0 to bit 6 leaves it unchanged. If an illegal access arrives in the same cycle as a clearing write, the flag ends up set.
- R10: `err_status` always equals bit 6 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered read data |
| glob_en | input | 1 | Global SMRAM enable |
| lock_in | input | 1 | Freezes the enable bits when 1 |
| open_in | input | 1 | SMRAM open; suppresses error logging |
| tseg_base | input | 32 | TSEG range base, inclusive |
| tseg_top | input | 32 | TSEG range top, exclusive |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Physical address of the access |
| acc_in_smm | input | 1 | Access made in system-management mode |
| dram_addr | output | 32 | Remapped or passed-through address |
| acc_hit | output | 1 | Access hit an active window |
| err_status | output | 1 | Invalid-access flag |

## Verification
The bench aims at the window edges 0xFEDA0000, 0xFEDBFFFF, 0xFED9FFFF and 0xFEDC0000, and at the TSEG base and top. A wrong compare at these edges would either hit one address too many or drop the last address of the window.

It also covers the following cases:
- Writes made under lock, and writes of zeros to the fixed-one bits. A broken lock path would let software move the windows after lock, and a writable fixed bit would read back as 0.
- A clearing write that lands in the same cycle as an illegal access. A design that lets the clear win would lose the error report.
- An access that hits both windows. A design that gives TSEG priority would pass the address through instead of remapping it.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int REG_W      = 8;
  localparam int POS_HIGH   = 7;
  localparam int POS_ERR    = 6;
  localparam int POS_TSEG   = 0;
  localparam logic [REG_W-1:0] FIXED_ONES = 8'h38;

  typedef struct packed {
    logic high_en;
    logic err;
    logic tseg_en;
  } smram_state_t;

  function automatic logic [REG_W-1:0] pack_reg(input smram_state_t s);
    logic [REG_W-1:0] v;
    v = FIXED_ONES;
    v[POS_HIGH] = s.high_en;
    v[POS_ERR]  = s.err;
    v[POS_TSEG] = s.tseg_en;
    return v;
  endfunction
endpackage

// File: rtl/smram_cfg_reg.sv
module smram_cfg_reg
  import smram_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sel,
  input  logic             rd_sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             lock_in,
  input  logic             set_err,
  output smram_state_t     state,
  output logic [REG_W-1:0] rdata
);
  smram_state_t st_q;
  logic         clr_err;

  assign clr_err = wr_sel && wdata[POS_ERR];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      rdata <= '0;
    end else begin
      if (wr_sel && !lock_in) begin
        st_q.high_en <= wdata[POS_HIGH];
        st_q.tseg_en <= wdata[POS_TSEG];
      end
      st_q.err <= set_err || (st_q.err && !clr_err);
      rdata    <= rd_sel ? pack_reg(st_q) : '0;
    end
  end

  assign state = st_q;

  // R4: a write while locked leaves the enables unchanged
  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && lock_in) |=> ($stable(st_q.high_en) && $stable(st_q.tseg_en)));
  // R9: a set request always leaves the flag set
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set_err |=> st_q.err);
  // R9: a clearing write with no set request clears the flag
  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_err && !set_err) |=> !st_q.err);
  // R3: the fixed-one bits read back as ones after a read
  assert_fixed_ones_R3: assert property (@(posedge clk) disable iff (rst)
    rd_sel |=> (rdata[5:3] == 3'b111 && rdata[2:1] == 2'b00));
endmodule

// File: rtl/smram_decode.sv
module smram_decode #(
  parameter int ADDR_W = 32,
  parameter int WIN_BITS = 17,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA0000,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h000A0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              high_act,
  input  logic              tseg_act,
  input  logic [ADDR_W-1:0] tseg_base,
  input  logic [ADDR_W-1:0] tseg_top,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_in_smm,
  input  logic              open_in,
  output logic              illegal,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              acc_hit
);
  localparam int TAG_W = ADDR_W - WIN_BITS;
  localparam logic [TAG_W-1:0] HIGH_TAG = HIGH_BASE[ADDR_W-1:WIN_BITS];
  localparam logic [TAG_W-1:0] LOW_TAG  = LOW_BASE[ADDR_W-1:WIN_BITS];

  logic in_high, in_tseg, hit_high, hit_tseg;
  logic [ADDR_W-1:0] mapped;

  assign in_high  = (acc_addr[ADDR_W-1:WIN_BITS] == HIGH_TAG);
  assign in_tseg  = (acc_addr >= tseg_base) && (acc_addr < tseg_top);
  assign hit_high = acc_valid && high_act && in_high;
  assign hit_tseg = acc_valid && tseg_act && in_tseg && !hit_high;
  assign illegal  = (hit_high || hit_tseg) && !acc_in_smm && !open_in;
  assign mapped   = hit_high ? {LOW_TAG, acc_addr[WIN_BITS-1:0]} : acc_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_addr <= '0;
      acc_hit   <= 1'b0;
    end else begin
      dram_addr <= acc_valid ? mapped : '0;
      acc_hit   <= hit_high || hit_tseg;
    end
  end

  // R5: a high-window hit keeps the offset and lands in the low window
  assert_remap_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && high_act && in_high) |=>
      (acc_hit && dram_addr[ADDR_W-1:WIN_BITS] == LOW_TAG &&
       dram_addr[WIN_BITS-1:0] == $past(acc_addr[WIN_BITS-1:0])));
  // R7: no valid access means no hit
  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!acc_hit && dram_addr == '0));
  // R6: a hit in TSEG outside the high window passes the address through
  assert_tseg_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && tseg_act && in_tseg && !in_high) |=>
      (acc_hit && dram_addr == $past(acc_addr)));
endmodule

// File: rtl/smram_ctl.sv
module smram_ctl
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] CFG_OFFSET = 8'h9E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              glob_en,
  input  logic              lock_in,
  input  logic              open_in,
  input  logic [ADDR_W-1:0] tseg_base,
  input  logic [ADDR_W-1:0] tseg_top,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_in_smm,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              acc_hit,
  output logic              err_status
);
  logic         sel, wr_sel, rd_sel, illegal;
  smram_state_t st;

  assign sel    = (cfg_addr == CFG_OFFSET);
  assign wr_sel = cfg_wr && sel;
  assign rd_sel = cfg_rd && sel;

  smram_cfg_reg u_reg (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .rd_sel(rd_sel),
    .wdata(cfg_wdata), .lock_in(lock_in), .set_err(illegal),
    .state(st), .rdata(cfg_rdata)
  );

  smram_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst),
    .high_act(glob_en && st.high_en), .tseg_act(glob_en && st.tseg_en),
    .tseg_base(tseg_base), .tseg_top(tseg_top),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_in_smm(acc_in_smm),
    .open_in(open_in), .illegal(illegal),
    .dram_addr(dram_addr), .acc_hit(acc_hit)
  );

  assign err_status = st.err;

  // R8: an access made in SMM or while open never raises the flag
  assert_no_err_legal_R8: assert property (@(posedge clk) disable iff (rst)
    (!err_status && (!acc_valid || acc_in_smm || open_in)) |=> !err_status);
  // R2: reads at other offsets return zero
  assert_other_read_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && !sel) |=> (cfg_rdata == '0));
endmodule

// File: tb/smram_ctl_tb_top.sv
module smram_ctl_tb_top;
  logic clk = 0;
  logic rst;
  logic [7:0] cfg_addr, cfg_wdata, cfg_rdata;
  logic cfg_wr, cfg_rd, glob_en, lock_in, open_in;
  logic [31:0] tseg_base, tseg_top, acc_addr, dram_addr;
  logic acc_valid, acc_in_smm, acc_hit, err_status;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_h, m_e, m_t;
  logic [31:0] e_dram;
  logic e_hit;
  logic [7:0] e_rd;

  always #10 clk = ~clk;

  smram_ctl dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] regval(input bit h, input bit e, input bit t);
    return {h, e, 3'b111, 2'b00, t};
  endfunction

  // One cycle: drive, update model, check after the edge.
  task automatic step(input logic [7:0] a, input bit wr, input bit rd, input logic [7:0] wd,
                      input bit v, input logic [31:0] ad, input bit smm);
    bit hh, ht, wsel;
    cfg_addr = a; cfg_wr = wr; cfg_rd = rd; cfg_wdata = wd;
    acc_valid = v; acc_addr = ad; acc_in_smm = smm;
    wsel = wr && (a == 8'h9E);
    hh = v && glob_en && m_h && (ad >= 32'hFEDA0000) && (ad <= 32'hFEDBFFFF);
    ht = v && glob_en && m_t && (ad >= tseg_base) && (ad < tseg_top) && !hh;
    e_hit  = hh || ht;
    e_dram = !v ? 32'h0 : hh ? (32'h000A0000 | {15'h0, ad[16:0]}) : ad;
    e_rd   = (rd && a == 8'h9E) ? regval(m_h, m_e, m_t) : 8'h00;
    m_e = ((hh || ht) && !smm && !open_in) || (m_e && !(wsel && wd[6]));
    if (wsel && !lock_in) begin m_h = wd[7]; m_t = wd[0]; end
    @(posedge clk); @(negedge clk);
    chk(hh ? "R5 hit" : ht ? "R6 hit" : "R7 hit", {31'h0, acc_hit}, {31'h0, e_hit});
    chk(hh ? "R5 addr" : ht ? "R6 addr" : "R7 addr", dram_addr, e_dram);
    chk("R2 rdata", {24'h0, cfg_rdata}, {24'h0, e_rd});
    chk("R8 err", {31'h0, err_status}, {31'h0, m_e});
  endtask

  task automatic idle();
    step(8'h00, 0, 0, 8'h00, 0, 32'h0, 0);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] ad;
    void'($urandom(32'd1234));
    rst = 1; cfg_addr = 0; cfg_wr = 0; cfg_rd = 0; cfg_wdata = 0;
    glob_en = 0; lock_in = 0; open_in = 0; acc_valid = 0; acc_addr = 0; acc_in_smm = 0;
    tseg_base = 32'h1F000000; tseg_top = 32'h1F100000;
    m_h = 0; m_e = 0; m_t = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R1 err", {31'h0, err_status}, 32'h0);
    chk("R1 hit", {31'h0, acc_hit}, 32'h0);
    step(8'h9E, 0, 1, 0, 0, 0, 0);
    chk("R1 reset value", {24'h0, cfg_rdata}, 32'h38);
    // R3 / R4: writing all ones and all zeros
    step(8'h9E, 1, 0, 8'hFF, 0, 0, 0);
    step(8'h9E, 0, 1, 0, 0, 0, 0);
    chk("R3 write FF", {24'h0, cfg_rdata}, 32'hB9);
    step(8'h9F, 1, 0, 8'h00, 0, 0, 0);
    step(8'h9E, 0, 1, 0, 0, 0, 0);
    chk("R2 other offset write", {24'h0, cfg_rdata}, 32'hB9);
    step(8'h9D, 0, 1, 0, 0, 0, 0);
    chk("R2 other offset read", {24'h0, cfg_rdata}, 32'h0);
    // R5 window edges
    glob_en = 1;
    step(0, 0, 0, 0, 1, 32'hFEDA0000, 1);
    chk("R5 low edge", dram_addr, 32'h000A0000);
    step(0, 0, 0, 0, 1, 32'hFEDBFFFF, 1);
    chk("R5 high edge", dram_addr, 32'h000BFFFF);
    step(0, 0, 0, 0, 1, 32'hFED9FFFF, 1);
    chk("R7 below window", {31'h0, acc_hit}, 32'h0);
    step(0, 0, 0, 0, 1, 32'hFEDC0000, 1);
    chk("R7 above window", {31'h0, acc_hit}, 32'h0);
    // R6 range edges
    step(0, 0, 0, 0, 1, 32'h1F000000, 1);
    chk("R6 base", {31'h0, acc_hit}, 32'h1);
    step(0, 0, 0, 0, 1, 32'h1F100000, 1);
    chk("R6 top excluded", {31'h0, acc_hit}, 32'h0);
    // R5 priority when both windows cover the address
    tseg_base = 32'hFED00000; tseg_top = 32'hFEE00000;
    step(0, 0, 0, 0, 1, 32'hFEDA1234, 1);
    chk("R5 priority", dram_addr, 32'h000A1234);
    tseg_base = 32'h1F000000; tseg_top = 32'h1F100000;
    // R8 / R9 / R10
    step(0, 0, 0, 0, 1, 32'hFEDA0010, 0);
    chk("R10 err set", {31'h0, err_status}, 32'h1);
    step(8'h9E, 1, 0, 8'hBF, 0, 0, 0);
    chk("R9 write zero keeps", {31'h0, err_status}, 32'h1);
    step(8'h9E, 1, 0, 8'hC1, 1, 32'h1F000040, 0);
    chk("R9 set wins", {31'h0, err_status}, 32'h1);
    step(8'h9E, 1, 0, 8'hC1, 0, 0, 0);
    chk("R9 clear", {31'h0, err_status}, 32'h0);
    open_in = 1;
    step(0, 0, 0, 0, 1, 32'hFEDA0010, 0);
    chk("R8 open suppresses", {31'h0, err_status}, 32'h0);
    open_in = 0;
    // R4 lock
    lock_in = 1;
    step(8'h9E, 1, 0, 8'h00, 0, 0, 0);
    step(8'h9E, 0, 1, 0, 0, 0, 0);
    chk("R4 locked write ignored", {24'h0, cfg_rdata}, 32'hB9);
    lock_in = 0;
    // Random phase, checked against the model inside step
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 3);
      ad = (k == 0) ? (32'hFED80000 + $urandom_range(0, 32'h7FFFF)) :
           (k == 1) ? (32'h1EFF0000 + $urandom_range(0, 32'h12FFFF)) : $urandom();
      if (i % 50 == 0) begin
        glob_en = $urandom_range(0, 3) != 0;
        lock_in = $urandom_range(0, 3) == 0;
        open_in = $urandom_range(0, 5) == 0;
      end
      step($urandom_range(0, 3) == 0 ? 8'h9E : 8'($urandom()),
           $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1, 8'($urandom()),
           $urandom_range(0, 2) != 0, ad, $urandom_range(0, 2) == 0);
    end
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule